// File: doc/BRIEF.md
# Load-Use Stall and Branch Cycle Accounting Unit

This unit sits beside an in-order pipeline and works out, for every retiring instruction, how many cycles it cost. The pipeline presents one instruction per clock, qualified by a valid strobe. With it come:

- the instruction class;
- up to two source register indices, each with a valid flag;
- the destination index used by loads;
- a base cycle count;
- a taken flag;
- a delay-slot attribute.

The unit adds load-use stall cycles and the branch penalty to the base count. It presents the result as the current instruction's cycle count, and keeps 32-bit running totals.

The unit models stalls only. It never holds the pipeline and never forwards data. A load marks its destination register in a 16-bit mask. Only the next retiring instruction compares its sources against that mask. Every matching source costs one extra cycle. A taken branch costs one extra cycle when it has no delay slot.

Top module: `cyc_acct_top`

## Requirements
- R1: After reset, every output reads zero and no register is marked as a pending load destination.
- R2: A valid load (class code 2) marks its destination register. The mark is seen only by the next valid instruction. Each valid instruction replaces the mark set: a load replaces it with its own destination, and any other class empties it. Cycles without a valid instruction leave the mark set untouched.
- R3: A source whose valid flag is low never adds a stall, whatever its index.
- R4: Execute (code 0) and store (code 3) instructions check both sources, A and B. Each checked source that hits a marked register adds one cycle to the instruction and one to the load-stall counter. Two hits therefore add two.
- R5: A load checks only source A (its base address). A branch (code 1) checks only source A. Source B of these classes never stalls.
- R6: A taken branch whose delay-slot flag is low adds one cycle and increments the branch-stall counter. A taken branch whose delay-slot flag is high adds nothing.
- R7: Each valid branch increments exactly one of the taken counter and the untaken counter, as chosen by its taken flag. For any other class, the taken flag has no effect on any count.
- R8: Load-multiple (code 4), store-multiple (code 5) and the unused codes 6 and 7 report their base count unchanged. They perform no stall check.
- R9: The instruction's final count appears on the current-cycle output one clock after the instruction is presented. The same count is added to the total-cycle counter in that same clock.
- R10: While the valid strobe is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction retires this cycle |
| in_class | input | 3 | Class: 0 execute, 1 branch, 2 load, 3 store, 4 load-multiple, 5 store-multiple |
| src_a_vld | input | 1 | Source A is present |
| src_a_idx | input | 4 | Source A register index (base address for loads) |
| src_b_vld | input | 1 | Source B is present |
| src_b_idx | input | 4 | Source B register index |
| dst_idx | input | 4 | Destination register of a load |
| base_cycles | input | 8 | Cycle count before penalties |
| br_taken | input | 1 | Branch was taken |
| br_delay_slot | input | 1 | Branch has a delay slot |
| cur_cycles_o | output | 32 | Final cycle count of the last instruction |
| total_o | output | 32 | Sum of all final cycle counts |
| ld_stall_o | output | 32 | Load-use stall cycles |
| br_stall_o | output | 32 | Branch penalty cycles |
| taken_o | output | 32 | Taken branches |
| untaken_o | output | 32 | Untaken branches |

## Verification
The hardest behaviour to reach from the ports is the lifetime of the load mark. A mark must survive idle cycles, yet disappear after exactly one consuming instruction. Reaching this takes deliberate sequences:

- a load, then several invalid cycles whose other inputs look like a different load;
- a consumer that must still stall, followed by a second consumer that must not;
- loads whose own base register hits the previous load's destination;
- reloads before each variant of a source-validity or class case, so that a single mark is tested against each case.

// File: rtl/cyc_acct_pkg.sv
package cyc_acct_pkg;
    localparam logic [2:0] CLS_EXEC   = 3'd0;
    localparam logic [2:0] CLS_BRANCH = 3'd1;
    localparam logic [2:0] CLS_LOAD   = 3'd2;
    localparam logic [2:0] CLS_STORE  = 3'd3;
    localparam logic [2:0] CLS_LDM    = 3'd4;
    localparam logic [2:0] CLS_STM    = 3'd5;
endpackage

// File: rtl/cyc_acct_hazard.sv
module cyc_acct_hazard #(
    parameter int NREG  = 16,
    parameter int NSRC  = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]             active_mask,
    input  logic [NSRC-1:0]             src_vld,
    input  logic [NSRC-1:0]             check_en,
    input  logic [NSRC-1:0][IDX_W-1:0]  src_idx,
    output logic [NSRC-1:0]             hit
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_comb begin
            hit[g] = check_en[g] && src_vld[g] && active_mask[src_idx[g]];
        end
    end
endmodule

// File: rtl/cyc_acct_branch.sv
module cyc_acct_branch (
    input  logic is_branch,
    input  logic taken,
    input  logic delay_slot,
    output logic penalty,
    output logic taken_inc,
    output logic untaken_inc
);
    always_comb begin
        taken_inc   = is_branch && taken;
        untaken_inc = is_branch && !taken;
        penalty     = taken_inc && !delay_slot;
    end
endmodule

// File: rtl/cyc_acct_top.sv
module cyc_acct_top
    import cyc_acct_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int CNT_W  = 32,
    parameter int BASE_W = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int NSRC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_class,
    input  logic              src_a_vld,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic              src_b_vld,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [BASE_W-1:0] base_cycles,
    input  logic              br_taken,
    input  logic              br_delay_slot,
    output logic [CNT_W-1:0]  cur_cycles_o,
    output logic [CNT_W-1:0]  total_o,
    output logic [CNT_W-1:0]  ld_stall_o,
    output logic [CNT_W-1:0]  br_stall_o,
    output logic [CNT_W-1:0]  taken_o,
    output logic [CNT_W-1:0]  untaken_o
);
    typedef struct packed {
        logic [NREG-1:0]  mask;
        logic [CNT_W-1:0] cur;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] ldst;
        logic [CNT_W-1:0] brst;
        logic [CNT_W-1:0] tk;
        logic [CNT_W-1:0] untk;
    } acct_t;

    acct_t st_d, st_q;

    logic [NSRC-1:0]            chk_en;
    logic [NSRC-1:0]            src_vld;
    logic [NSRC-1:0][IDX_W-1:0] src_idx;
    logic [NSRC-1:0]            hit;
    logic                       is_br, pen, tk_inc, untk_inc;

    always_comb begin
        is_br     = (in_class == CLS_BRANCH);
        chk_en[0] = (in_class == CLS_EXEC) || (in_class == CLS_STORE) ||
                    (in_class == CLS_LOAD) || is_br;
        chk_en[1] = (in_class == CLS_EXEC) || (in_class == CLS_STORE);
        src_vld   = {src_b_vld, src_a_vld};
        src_idx   = {src_b_idx, src_a_idx};
    end

    cyc_acct_hazard #(.NREG(NREG), .NSRC(NSRC)) i_hazard (
        .active_mask (st_q.mask),
        .src_vld     (src_vld),
        .check_en    (chk_en),
        .src_idx     (src_idx),
        .hit         (hit)
    );

    cyc_acct_branch i_branch (
        .is_branch   (is_br),
        .taken       (br_taken),
        .delay_slot  (br_delay_slot),
        .penalty     (pen),
        .taken_inc   (tk_inc),
        .untaken_inc (untk_inc)
    );

    always_comb begin
        logic [CNT_W-1:0] nstall;
        logic [CNT_W-1:0] cyc;
        st_d   = st_q;
        nstall = CNT_W'($countones(hit));
        cyc    = CNT_W'(base_cycles) + nstall + CNT_W'(pen);
        if (in_valid) begin
            st_d.mask  = (in_class == CLS_LOAD) ? (NREG'(1) << dst_idx) : '0;
            st_d.cur   = cyc;
            st_d.total = st_q.total + cyc;
            st_d.ldst  = st_q.ldst + nstall;
            st_d.brst  = st_q.brst + CNT_W'(pen);
            st_d.tk    = st_q.tk + CNT_W'(tk_inc);
            st_d.untk  = st_q.untk + CNT_W'(untk_inc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_cycles_o = st_q.cur;
    assign total_o      = st_q.total;
    assign ld_stall_o   = st_q.ldst;
    assign br_stall_o   = st_q.brst;
    assign taken_o      = st_q.tk;
    assign untaken_o    = st_q.untk;

    // R2: at most one register marked
    p_mask_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.mask));

    // R9: total advances by the reported count
    p_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> total_o == $past(total_o) + cur_cycles_o);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(total_o) && $stable(cur_cycles_o) && $stable(ld_stall_o)
                      && $stable(br_stall_o) && $stable(taken_o) && $stable(untaken_o));

    p_multi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_class == CLS_LDM || in_class == CLS_STM)
        |=> cur_cycles_o == CNT_W'($past(base_cycles)) && $stable(ld_stall_o));

    p_branch_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_br |=> CNT_W'(taken_o + untaken_o) == CNT_W'($past(taken_o + untaken_o) + 1));

    p_nonbranch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_br |=> $stable(taken_o) && $stable(untaken_o) && $stable(br_stall_o));

    // R4: at most two stall cycles per instruction
    p_stall_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ld_stall_o - $past(ld_stall_o) <= CNT_W'(2));
endmodule

// File: tb/test_cyc_acct_top.sv
module test_cyc_acct_top;
    localparam int PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0;
    logic [2:0] in_class = 0;
    logic src_a_vld = 0, src_b_vld = 0;
    logic [3:0] src_a_idx = 0, src_b_idx = 0, dst_idx = 0;
    logic [7:0] base_cycles = 0;
    logic br_taken = 0, br_delay_slot = 0;
    logic [31:0] cur_cycles_o, total_o, ld_stall_o, br_stall_o, taken_o, untaken_o;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_mask = 0;
    logic [31:0] m_cur = 0, m_tot = 0, m_ld = 0, m_br = 0, m_tk = 0, m_utk = 0;

    always #(PERIOD/2) clk = ~clk;

    cyc_acct_top i_cyc_acct_top (.*);

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "cur", cur_cycles_o, m_cur);
        check(tag, "total", total_o, m_tot);
        check(tag, "ld_stall", ld_stall_o, m_ld);
        check(tag, "br_stall", br_stall_o, m_br);
        check(tag, "taken", taken_o, m_tk);
        check(tag, "untaken", untaken_o, m_utk);
    endtask

    task automatic send(string tag, logic [2:0] cls, logic av, logic [3:0] ai,
                        logic bv, logic [3:0] bi, logic [3:0] dst, logic [7:0] base,
                        logic tk, logic ds);
        logic ca, cb, br;
        int stl;
        @(negedge clk);
        in_valid = 1; in_class = cls; src_a_vld = av; src_a_idx = ai;
        src_b_vld = bv; src_b_idx = bi; dst_idx = dst; base_cycles = base;
        br_taken = tk; br_delay_slot = ds;
        br  = (cls == 3'd1);
        ca  = (cls <= 3'd3);
        cb  = (cls == 3'd0) || (cls == 3'd3);
        stl = int'(ca && av && m_mask[ai]) + int'(cb && bv && m_mask[bi]);
        m_cur = 32'(base) + 32'(stl) + 32'(br && tk && !ds);
        m_tot += m_cur;
        m_ld  += 32'(stl);
        m_br  += 32'(br && tk && !ds);
        m_tk  += 32'(br && tk);
        m_utk += 32'(br && !tk);
        m_mask = (cls == 3'd2) ? (16'd1 << dst) : 16'd0;
        @(negedge clk);
        in_valid = 0;
        check_all(tag);
    endtask

    task automatic t_reset;
        check_all("R1");
    endtask

    task automatic t_exec_two_hits;
        send("R2", 3'd2, 1, 4'd0, 0, 4'd0, 4'd5, 8'd2, 0, 0);
        send("R4", 3'd0, 1, 4'd5, 1, 4'd5, 4'd0, 8'd1, 0, 0);
        send("R2", 3'd0, 1, 4'd5, 0, 4'd0, 4'd0, 8'd1, 0, 0);
    endtask

    task automatic t_store;
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd3, 8'd2, 0, 0);
        send("R4", 3'd3, 1, 4'd1, 1, 4'd3, 4'd0, 8'd1, 0, 0);
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd3, 8'd2, 0, 0);
        send("R4", 3'd3, 1, 4'd3, 1, 4'd1, 4'd0, 8'd1, 0, 0);
    endtask

    task automatic t_invalid;
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd7, 8'd2, 0, 0);
        send("R3", 3'd0, 0, 4'd7, 1, 4'd7, 4'd0, 8'd1, 0, 0);
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd7, 8'd2, 0, 0);
        send("R3", 3'd3, 0, 4'd7, 0, 4'd7, 4'd0, 8'd3, 0, 0);
    endtask

    task automatic t_load_branch_src;
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd2, 8'd2, 0, 0);
        send("R5", 3'd2, 1, 4'd9, 1, 4'd2, 4'd4, 8'd2, 0, 0);
        send("R5", 3'd2, 1, 4'd4, 0, 4'd0, 4'd6, 8'd2, 0, 0);
        send("R5", 3'd1, 0, 4'd0, 1, 4'd6, 4'd0, 8'd1, 0, 0);
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd11, 8'd2, 0, 0);
        send("R5", 3'd1, 1, 4'd11, 0, 4'd0, 4'd0, 8'd1, 1, 0);
    endtask

    task automatic t_branch;
        send("R6", 3'd1, 0, 4'd0, 0, 4'd0, 4'd0, 8'd1, 1, 0);
        send("R6", 3'd1, 0, 4'd0, 0, 4'd0, 4'd0, 8'd1, 1, 1);
        send("R7", 3'd1, 0, 4'd0, 0, 4'd0, 4'd0, 8'd1, 0, 0);
        send("R7", 3'd1, 0, 4'd0, 0, 4'd0, 4'd0, 8'd1, 0, 1);
        send("R7", 3'd0, 0, 4'd0, 0, 4'd0, 4'd0, 8'd1, 1, 0);
        send("R7", 3'd3, 0, 4'd0, 0, 4'd0, 4'd0, 8'd2, 1, 1);
    endtask

    task automatic t_multi;
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd1, 8'd2, 0, 0);
        send("R8", 3'd4, 1, 4'd1, 1, 4'd1, 4'd0, 8'd9, 1, 0);
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd1, 8'd2, 0, 0);
        send("R8", 3'd5, 1, 4'd1, 1, 4'd1, 4'd0, 8'd255, 0, 0);
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd1, 8'd2, 0, 0);
        send("R8", 3'd6, 1, 4'd1, 1, 4'd1, 4'd0, 8'd4, 1, 0);
    endtask

    task automatic t_idle;
        send("R2", 3'd2, 0, 4'd0, 0, 4'd0, 4'd8, 8'd2, 0, 0);
        @(negedge clk);
        in_class = 3'd2; dst_idx = 4'd9; src_a_vld = 1; src_a_idx = 4'd8;
        base_cycles = 8'd77; br_taken = 1;
        repeat (5) @(negedge clk);
        check_all("R10");
        send("R2", 3'd0, 1, 4'd8, 1, 4'd9, 4'd0, 8'd1, 0, 0);
        send("R9", 3'd0, 1, 4'd8, 0, 4'd0, 4'd0, 8'd200, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_exec_two_hits();
        t_store();
        t_invalid();
        t_load_branch_src();
        t_branch();
        t_multi();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule